// File: doc/BRIEF.md
# Shadowed Control Register Bank with Bit-Masked Writes

This block holds a small set of 32-bit control words behind a one-cycle register port. The port has an address, write data, a write strobe, a read strobe and read data. Software writes only to staged (shadow) copies. The datapath sees only the live (active) copies, so a group of settings changes all at once and never partway through a frame.

A word is built as one of two kinds, chosen per word by a parameter bitmap:
- A **masked** word keeps 16 data bits. On a write, the upper half of the write data says which of those 16 bits take the new value. Software can therefore change one field without a read-modify-write.
- A **plain** word is replaced whole by each write.

Software sets a commit flag in a control word. On the next frame-start pulse, every active copy loads from its shadow at once. The flag then clears itself.

Word i sits at byte offset 4·i on a 12-bit address. The control word sits just above the last data word, at offset 4·NUM_REGS (0x020 with the default eight words). Any other offset is unmapped, and so is any offset whose two low bits are not zero.

Top module: `cfg_shadow_bank`

## Requirements
- R1: During and after synchronous active-low reset, every shadow word, every active word and the commit flag are zero.
- R2: A write to a masked word at offset 4·i (bit i of MASKED_MAP set) updates shadow bit k (k = 0..15) from wdata[k] only when wdata[k+16] is 1. Bits whose enable is 0 keep their value.
- R3: The upper 16 bits of a masked word read back as zero, and its active copy's upper 16 bits are zero.
- R4: A write to a plain word (bit i of MASKED_MAP clear) replaces all 32 shadow bits with wdata.
- R5: While rd_en is 1, rdata combinationally shows the shadow word at offset addr. While rd_en is 0, rdata is zero.
- R6: Writes to data words do not change active_o until a commit.
- R7: Writing the control word with wdata[0]=1 sets the commit flag, which reads back as bit 0 of the control word. All other bits of the control word read zero. Writing wdata[0]=0 leaves the flag unchanged.
- R8: At a clock edge where frame_start is 1 and the commit flag is already set, every active word takes the shadow value held before that edge. At the same edge the commit flag clears.
- R9: A frame_start pulse while the commit flag is clear leaves active_o unchanged.
- R10: A write to an unmapped or misaligned offset changes no word and no flag. A read from such an offset returns zero.
- R11: A control-word write with wdata[0]=1 at the same edge as frame_start sets the flag without committing. A data write at a commit edge reaches the shadow only, and the active copy takes the earlier shadow value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data; for masked words the upper half holds per-bit enables |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Read data (combinational) |
| frame_start | input | 1 | One-cycle frame-start pulse |
| active_o | output | 32·NUM_REGS | Active copies, word i at bits [32·i+31:32·i] |

## Verification
The collision that matters is a commit edge that coincides with a register access. A frame-start pulse can land in the same cycle as a data write, or in the same cycle as a write that sets the commit flag. Directed steps force both pairings. Random stimulus raises frame_start in about a quarter of the cycles, interleaved with writes to every word kind, to the control word and to unmapped offsets. A bench model applies the commit from the old shadow state before applying the write, and the active vector and a read are compared against it after every cycle.

// File: rtl/cfgbank_pkg.sv
// Package: shared widths and the bit-merge helper for the shadowed register bank.
// Assumes a 32-bit word whose upper half carries per-bit enables on masked words.
package cfgbank_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int IDX_W  = ADDR_W - 2;

    // Merge new bits into old bits where the enable is set.
    function automatic logic [HALF_W-1:0] bit_merge(
        input logic [HALF_W-1:0] old_bits,
        input logic [HALF_W-1:0] new_bits,
        input logic [HALF_W-1:0] enables
    );
        return (old_bits & ~enables) | (new_bits & enables);
    endfunction
endpackage

// File: rtl/cfgbank_decode.sv
// Address decoder: turns a byte offset into a one-hot data-word select and a
// control-word hit. Assumes word-aligned offsets; misaligned ones hit nothing.
module cfgbank_decode
    import cfgbank_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] word_sel,
    output logic                ctrl_hit,
    output logic                any_hit
);
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(NUM_REGS);

    logic [IDX_W-1:0] word_idx;
    logic             aligned;

    assign word_idx = addr[ADDR_W-1:2];
    assign aligned  = (addr[1:0] == 2'b00);

    // Compare the word index against each data-word slot.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            word_sel[i] = aligned && (word_idx == IDX_W'(i));
        end
    end

    assign ctrl_hit = aligned && (word_idx == CTRL_IDX);
    assign any_hit  = ctrl_hit || (|word_sel);

    AST_SEL_ONEHOT: assert final ($onehot0({word_sel, ctrl_hit}))   // R10
        else $error("decoder selected more than one word");
endmodule

// File: rtl/cfgbank_word.sv
// One control word: a shadow copy written from the bus and an active copy
// loaded from the shadow on commit. MASKED picks the per-bit-enable variant,
// which stores only the lower half and reads zero in the upper half.
module cfgbank_word
    import cfgbank_pkg::*;
#(
    parameter bit MASKED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] shadow_o,
    output logic [DATA_W-1:0] active_o
);
    generate
        if (MASKED) begin : g_masked
            logic [HALF_W-1:0] shadow_q;
            logic [HALF_W-1:0] active_q;

            // Stage enabled bits into the shadow half-word.
            always_ff @(posedge clk) begin
                if (!rst_n)      shadow_q <= '0;
                else if (wr_sel) shadow_q <= bit_merge(shadow_q, wdata[HALF_W-1:0],
                                                       wdata[DATA_W-1:HALF_W]);
            end

            // Load the live half-word from the shadow on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)      active_q <= '0;
                else if (commit) active_q <= shadow_q;
            end

            assign shadow_o = {{HALF_W{1'b0}}, shadow_q};
            assign active_o = {{HALF_W{1'b0}}, active_q};

            AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
                wr_sel |=> (((shadow_o[HALF_W-1:0] ^ $past(shadow_o[HALF_W-1:0]))
                             & ~$past(wdata[DATA_W-1:HALF_W])) == '0))   // R2
                else $error("disabled bit changed");
        end else begin : g_plain
            logic [DATA_W-1:0] shadow_q;
            logic [DATA_W-1:0] active_q;

            // Replace the whole shadow word on a write.
            always_ff @(posedge clk) begin
                if (!rst_n)      shadow_q <= '0;
                else if (wr_sel) shadow_q <= wdata;
            end

            // Load the live word from the shadow on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)      active_q <= '0;
                else if (commit) active_q <= shadow_q;
            end

            assign shadow_o = shadow_q;
            assign active_o = active_q;

            AST_PLAIN_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
                wr_sel |=> (shadow_o == $past(wdata)))   // R4
                else $error("plain word not replaced");
        end
    endgenerate

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_o))   // R6
        else $error("active changed without commit");

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_o == $past(shadow_o)))   // R8
        else $error("active did not take prior shadow");

    AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(shadow_o))   // R10
        else $error("shadow changed without its write");
endmodule

// File: rtl/cfgbank_commit.sv
// Commit sequencer: holds the commit flag set by software and fires a one-cycle
// commit on the first frame-start after it. Assumes frame_start is a pulse.
module cfgbank_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic frame_start,
    output logic pending_o,
    output logic commit_o
);
    logic pending_q;

    // Set on request, clear when a frame start consumes it; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= 1'b0;
        else        pending_q <= set_req | (pending_q & ~frame_start);
    end

    assign pending_o = pending_q;
    assign commit_o  = pending_q & frame_start;

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending_o) |-> $past(set_req))   // R7
        else $error("flag rose without request");

    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_o && !set_req) |=> !pending_o)   // R8
        else $error("flag stayed after commit");

    AST_SAME_EDGE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && frame_start) |=> pending_o)   // R11
        else $error("same-edge request lost");
endmodule

// File: rtl/cfg_shadow_bank.sv
// Top: shadowed control register bank. Data words sit at offset 4*i, the
// control word (bit 0 = commit flag) at 4*NUM_REGS. MASKED_MAP bit i makes
// word i a per-bit-enable word. Reads are combinational and side-effect free.
module cfg_shadow_bank
    import cfgbank_pkg::*;
#(
    parameter int                  NUM_REGS   = 8,
    parameter logic [NUM_REGS-1:0] MASKED_MAP = 8'hA5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       wr_en,
    input  logic                       rd_en,
    output logic [DATA_W-1:0]          rdata,
    input  logic                       frame_start,
    output logic [NUM_REGS*DATA_W-1:0] active_o
);
    logic [NUM_REGS-1:0] word_sel;
    logic                ctrl_hit;
    logic                any_hit;
    logic                pending;
    logic                commit;
    logic [DATA_W-1:0]   shadow_w [NUM_REGS];
    logic [DATA_W-1:0]   rd_mux;

    cfgbank_decode #(.NUM_REGS(NUM_REGS)) i_decode (
        .addr     (addr),
        .word_sel (word_sel),
        .ctrl_hit (ctrl_hit),
        .any_hit  (any_hit)
    );

    cfgbank_commit i_commit (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_req     (wr_en && ctrl_hit && wdata[0]),
        .frame_start (frame_start),
        .pending_o   (pending),
        .commit_o    (commit)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        cfgbank_word #(.MASKED(MASKED_MAP[i])) i_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_en && word_sel[i]),
            .wdata    (wdata),
            .commit   (commit),
            .shadow_o (shadow_w[i]),
            .active_o (active_o[i*DATA_W +: DATA_W])
        );
    end

    // Select the addressed word for readback.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (word_sel[i]) rd_mux = rd_mux | shadow_w[i];
        end
        if (ctrl_hit) rd_mux = {{(DATA_W-1){1'b0}}, pending};
    end

    assign rdata = rd_en ? rd_mux : '0;

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !any_hit) |-> (rdata == '0))   // R10
        else $error("unmapped read nonzero");

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0))   // R5
        else $error("rdata nonzero without read");

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (active_o == '0))   // R1
        else $error("active not cleared by reset");
endmodule

// File: tb/test_cfg_shadow_bank.sv
module test_cfg_shadow_bank;
    localparam int          CLK_PERIOD = 10;
    localparam int          NREG       = 8;
    localparam logic [7:0]  MMAP       = 8'hA5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       addr = '0;
    logic [31:0]       wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [31:0]       rdata;
    logic              frame_start = 1'b0;
    logic [NREG*32-1:0] active_o;

    logic [31:0] sh_m  [NREG];
    logic [31:0] act_m [NREG];
    logic        pend_m;
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_shadow_bank i_cfg_shadow_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .frame_start(frame_start), .active_o(active_o)
    );

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int idx;
        if (a[1:0] != 2'b00) return 32'h0;
        idx = int'(a[11:2]);
        if (idx < NREG)  return sh_m[idx];
        if (idx == NREG) return {31'b0, pend_m};
        return 32'h0;
    endfunction

    function automatic logic [NREG*32-1:0] exp_active();
        logic [NREG*32-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*32 +: 32] = act_m[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [NREG*32-1:0] act,
                         input logic [NREG*32-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model update for one edge: commit from old shadow first, then the write.
    task automatic model_edge(input logic [11:0] a, input logic [31:0] d,
                              input logic we, input logic fs);
        int  idx;
        bit  cmt;
        cmt = fs && pend_m;
        if (cmt) begin
            for (int i = 0; i < NREG; i++) act_m[i] = sh_m[i];
            pend_m = 1'b0;
        end
        if (we && a[1:0] == 2'b00) begin
            idx = int'(a[11:2]);
            if (idx < NREG) begin
                if (MMAP[idx])
                    sh_m[idx] = {16'h0, (sh_m[idx][15:0] & ~d[31:16]) | (d[15:0] & d[31:16])};
                else
                    sh_m[idx] = d;
            end else if (idx == NREG && d[0]) begin
                pend_m = 1'b1;
            end
        end
    endtask

    task automatic cycle(input logic [11:0] a, input logic [31:0] d,
                         input logic we, input logic fs);
        @(negedge clk);
        addr = a; wdata = d; wr_en = we; frame_start = fs;
        @(posedge clk);
        model_edge(a, d, we, fs);
        @(negedge clk);
        wr_en = 1'b0; frame_start = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        logic [31:0] e;
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        e = exp_read(a);
        check(rdata == e, req, {{(NREG-1)*32{1'b0}}, rdata}, {{(NREG-1)*32{1'b0}}, e});
        rd_en = 1'b0;
    endtask

    task automatic check_active(input string req);
        #1;
        check(active_o == exp_active(), req, active_o, exp_active());
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd12345));
        for (int i = 0; i < NREG; i++) begin sh_m[i] = '0; act_m[i] = '0; end
        pend_m = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        check_active("R1 active after reset");
        for (int i = 0; i <= NREG; i++) do_read(12'(4*i), "R1 word after reset");

        // R5: no read strobe gives zero
        @(negedge clk); addr = 12'h004; #1;
        check(rdata == 32'h0, "R5 idle rdata", {224'h0, rdata}, '0);

        // R2: masked word 0, partial enables
        cycle(12'h000, 32'hFFFF_1234, 1'b1, 1'b0);
        cycle(12'h000, 32'h00F0_0F0F, 1'b1, 1'b0);
        @(negedge clk); addr = 12'h000; rd_en = 1'b1; #1;
        check(rdata == 32'h0000_1204, "R2 masked merge", {224'h0, rdata}, {224'h0, 32'h0000_1204});
        rd_en = 1'b0;
        // R3: upper half reads zero
        cycle(12'h008, 32'hFFFF_ABCD, 1'b1, 1'b0);
        do_read(12'h008, "R3 masked upper zero");
        // R4: plain word replaced
        cycle(12'h004, 32'hDEAD_BEEF, 1'b1, 1'b0);
        cycle(12'h004, 32'h0BAD_F00D, 1'b1, 1'b0);
        do_read(12'h004, "R4 plain replace");
        // R6: active unchanged by writes
        check_active("R6 no commit yet");
        // R9: frame start without flag
        cycle(12'h000, 32'h0, 1'b0, 1'b1);
        check_active("R9 no flag no commit");
        // R7: flag set and readback; zero write keeps it
        cycle(12'h020, 32'h0000_0001, 1'b1, 1'b0);
        do_read(12'h020, "R7 flag readback");
        cycle(12'h020, 32'hFFFF_FFFE, 1'b1, 1'b0);
        do_read(12'h020, "R7 zero write keeps flag");
        check_active("R6 flag alone no commit");
        // R8: commit on frame start, flag clears
        cycle(12'h000, 32'h0, 1'b0, 1'b1);
        check_active("R8 commit loads shadows");
        check(active_o[63:32] == 32'h0BAD_F00D, "R8 plain active", {224'h0, active_o[63:32]}, {224'h0, 32'h0BAD_F00D});
        check(active_o[95:64] == 32'h0000_ABCD, "R3 active upper zero", {224'h0, active_o[95:64]}, {224'h0, 32'h0000_ABCD});
        do_read(12'h020, "R8 flag cleared");
        // R10: unmapped and misaligned
        cycle(12'h024, 32'hFFFF_FFFF, 1'b1, 1'b0);
        cycle(12'h006, 32'hFFFF_FFFF, 1'b1, 1'b0);
        cycle(12'hFFC, 32'hFFFF_FFFF, 1'b1, 1'b0);
        cycle(12'h021, 32'hFFFF_FFFF, 1'b1, 1'b0);
        do_read(12'h024, "R10 unmapped read");
        do_read(12'h006, "R10 misaligned read");
        do_read(12'h020, "R10 flag untouched");
        for (int i = 0; i < NREG; i++) do_read(12'(4*i), "R10 words untouched");
        // R11: flag set at frame start does not commit
        cycle(12'h004, 32'h1111_2222, 1'b1, 1'b0);
        cycle(12'h020, 32'h1, 1'b1, 1'b1);
        check_active("R11 same-edge set no commit");
        do_read(12'h020, "R11 flag set");
        // R11: data write at commit edge
        cycle(12'h004, 32'h3333_4444, 1'b1, 1'b1);
        check(active_o[63:32] == 32'h1111_2222, "R11 commit takes old shadow",
              {224'h0, active_o[63:32]}, {224'h0, 32'h1111_2222});
        do_read(12'h004, "R11 shadow has new write");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int          r;
            logic [11:0] a;
            r = int'($urandom % 16);
            if (r < 9)       a = 12'(4*r);
            else if (r < 12) a = 12'($urandom);
            else             a = 12'h020;
            cycle(a, $urandom, ($urandom % 5) != 0, ($urandom % 4) == 0);
            check_active("R8 random active");
            do_read(12'($urandom % 40), "R5 random read");
        end

        finish_run();
    end
endmodule